// File: doc/BRIEF.md
# Debug Command Port Slave

This block sits on the chip side of a narrow parallel debug port. An external debug controller drives an 8-bit command code with a 32-bit data word and reads back a 14-bit status word. The block turns each command into an internal action: a register or memory/I/O access through simple request/acknowledge ports, run/halt/single-step control of the core, console mode entry and exit, a trap enable mask, a debug-logic reset, or switching a real-time trace stream on and off. While tracing, words from the core's trace source are presented on the outgoing data bus, one at a time. The host takes each word through its own acknowledge.

Commands use a valid/ready handshake. `cmd_valid` is sampled only while status bit 0 (ready) is high. Once a command is taken, ready stays low until that command's completion bit is set. Writes that carry an address use two phases. The register number or address comes with the command. The value comes on a later transfer with `dat_valid`/`dat_ready`, and the host may delay it for any number of cycles. The trace path is also valid/ready. The core sees back-pressure through `trc_ready` whenever a word is still waiting and the host has not taken it. The port pins are shared with self-test and boundary-scan logic, so `dbg_en` low parks the port.

Top module: `dbg_cmd_port`

## Requirements
- R1: The status word carries: bit 0 ready, bit 1 done, bit 2 trace word valid, bit 3 error, bit 4 refused, bit 5 core running, bit 6 console mode, bit 7 tracing, bit 8 awaiting write data. Bits 13:9 are zero. After reset, ready is 1 and every other bit is 0.
- R1 (continued): A command is taken on an edge where `cmd_valid` and ready are both high. Ready then stays low until that command completes. Done clears when a command is taken. Done is set on the cycle after completion and holds until the next command is taken.
- R2: Opcode 0x01 reads a register and 0x02 writes one. The register number is `dbus_in[4:0]`, and higher bits are ignored. The number is driven zero-extended on `acc_addr` while `reg_req` is high.
- R3: Opcodes 0x03/0x04 read/write memory and 0x05/0x06 read/write I/O. The full 32-bit address is driven on `acc_addr` with `mem_req` high. `mem_io` is 1 only for the I/O opcodes.
- R4: A write waits in the data phase (`dat_ready`=1, status bit 8) until `dat_valid`. It then issues the access with that value on `acc_wdata` and `acc_we`=1. A read, once acknowledged, puts its value on `dbus_out` with `dbus_oe`=1 until the next command is taken.
- R5: An access request stays high, with a stable address, until its acknowledge. Done is set on the following cycle.
- R6: Opcode 0x07 sets running and 0x08 clears it. Opcode 0x09 pulses `cpu_step` for exactly one cycle, but only when the core is not running.
- R7: Opcode 0x0A sets console mode and 0x0B clears it.
- R8: Opcode 0x0D starts trace and 0x0E stops it. While tracing, a word taken from the core is held on `dbus_out` with status bit 2 set until `trc_take`. `trc_ready` is low while a word waits and `trc_take` is low.
- R9: While trace is off, `trc_ready` is 1 and incoming trace words are discarded. Stopping trace drops any waiting word.
- R10: While tracing, opcodes 0x01-0x06, 0x10 and 0x11 are refused. Refusal sets sticky bit 4 and done, and issues no request.
- R11: An opcode above 0x12 sets sticky bit 3 and done, and changes no other state.
- R12: Opcode 0x0C clears the trap mask, console mode, tracing and both sticky flags, and leaves running unchanged. Opcode 0x12 clears only the sticky flags. Opcode 0x00 does nothing except complete.
- R13: Opcode 0x0F loads `trap_mask` from `dbus_in[15:0]`. Opcode 0x10 returns the mask zero-extended. Opcode 0x11 returns the identity constant 0x0D1B0001.
- R14: While `dbg_en` is low, ready, `dat_ready` and `dbus_oe` are 0 and no command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Port owned by debug logic |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 8 | Command code |
| dbus_in | input | 32 | Inbound data bus |
| dat_valid | input | 1 | Write value present on dbus_in |
| dat_ready | output | 1 | Write value awaited |
| status | output | 14 | Status word |
| dbus_out | output | 32 | Outbound data bus |
| dbus_oe | output | 1 | Outbound bus driven |
| reg_req | output | 1 | Register access request |
| reg_ack | input | 1 | Register access acknowledge |
| reg_rdata | input | 32 | Register read value |
| mem_req | output | 1 | Memory/I/O access request |
| mem_io | output | 1 | Access targets I/O space |
| mem_ack | input | 1 | Memory/I/O acknowledge |
| mem_rdata | input | 32 | Memory/I/O read value |
| acc_we | output | 1 | Access is a write |
| acc_addr | output | 32 | Access address or register number |
| acc_wdata | output | 32 | Access write value |
| cpu_run | output | 1 | Core run enable |
| cpu_step | output | 1 | Single-step pulse |
| console_mode | output | 1 | Console mode active |
| trap_mask | output | 16 | Trap enable mask |
| trc_valid | input | 1 | Trace word from core valid |
| trc_data | input | 32 | Trace word from core |
| trc_ready | output | 1 | Trace word accepted |
| trc_take | input | 1 | Host takes presented trace word |

## Verification
The assertions check properties that hold on every cycle:
- ready is never high alongside a pending access or with the port parked;
- a request holds its address until acknowledged;
- a held trace word stays put until taken;
- step is a single-cycle pulse;
- an unknown opcode touches nothing but the error flag;
- a refused command raises no request.

Only the bench scenarios show the data-carrying behaviour: read values landing on the bus, delayed write data, the mask and identity readback, the split between the two reset-style commands, and trace words arriving in order under a varying take pattern.

// File: rtl/dbg_cmd_port_pkg.sv
`timescale 1ns/1ps
package dbg_cmd_port_pkg;

  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_RD_REG  = 8'h01;
  localparam logic [7:0] OP_WR_REG  = 8'h02;
  localparam logic [7:0] OP_RD_MEM  = 8'h03;
  localparam logic [7:0] OP_WR_MEM  = 8'h04;
  localparam logic [7:0] OP_RD_IO   = 8'h05;
  localparam logic [7:0] OP_WR_IO   = 8'h06;
  localparam logic [7:0] OP_RUN     = 8'h07;
  localparam logic [7:0] OP_HALT    = 8'h08;
  localparam logic [7:0] OP_STEP    = 8'h09;
  localparam logic [7:0] OP_CON_ON  = 8'h0A;
  localparam logic [7:0] OP_CON_OFF = 8'h0B;
  localparam logic [7:0] OP_DBG_RST = 8'h0C;
  localparam logic [7:0] OP_TRC_ON  = 8'h0D;
  localparam logic [7:0] OP_TRC_OFF = 8'h0E;
  localparam logic [7:0] OP_WR_MASK = 8'h0F;
  localparam logic [7:0] OP_RD_MASK = 8'h10;
  localparam logic [7:0] OP_RD_ID   = 8'h11;
  localparam logic [7:0] OP_CLR_FLG = 8'h12;
  localparam logic [7:0] OP_LAST    = OP_CLR_FLG;

  localparam int SW = 14;
  localparam int ST_READY   = 0;
  localparam int ST_DONE    = 1;
  localparam int ST_TVALID  = 2;
  localparam int ST_ERR     = 3;
  localparam int ST_REFUSED = 4;
  localparam int ST_RUN     = 5;
  localparam int ST_CONSOLE = 6;
  localparam int ST_TRACING = 7;
  localparam int ST_WANTDAT = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_ISSUE} phase_e;

  typedef struct packed {
    logic known;
    logic bus;
    logic rd_acc;
    logic wr_acc;
    logic tgt_reg;
    logic io;
  } cmd_cls_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
`timescale 1ns/1ps
module dbg_cmd_decode
  import dbg_cmd_port_pkg::*;
(
  input  logic [7:0] op,
  output cmd_cls_t   cls
);
  always_comb begin
    cls = '0;
    cls.known = (op <= OP_LAST);
    case (op)
      OP_RD_REG:  begin cls.bus = 1'b1; cls.rd_acc = 1'b1; cls.tgt_reg = 1'b1; end
      OP_WR_REG:  begin cls.bus = 1'b1; cls.wr_acc = 1'b1; cls.tgt_reg = 1'b1; end
      OP_RD_MEM:  begin cls.bus = 1'b1; cls.rd_acc = 1'b1; end
      OP_WR_MEM:  begin cls.bus = 1'b1; cls.wr_acc = 1'b1; end
      OP_RD_IO:   begin cls.bus = 1'b1; cls.rd_acc = 1'b1; cls.io = 1'b1; end
      OP_WR_IO:   begin cls.bus = 1'b1; cls.wr_acc = 1'b1; cls.io = 1'b1; end
      OP_RD_MASK: cls.bus = 1'b1;
      OP_RD_ID:   cls.bus = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/dbg_cmd_seq.sv
`timescale 1ns/1ps
module dbg_cmd_seq
  import dbg_cmd_port_pkg::*;
#(
  parameter int DW = 32,
  parameter int REG_W = 5,
  parameter int NTRAP = 16,
  parameter logic [DW-1:0] PORT_ID = 32'h0D1B_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [DW-1:0]    din,
  input  logic             dat_valid,
  output logic             ready,
  output logic             dat_ready,
  output logic             done,
  output logic             err,
  output logic             refd,
  output logic             run,
  output logic             con,
  output logic             trc_on,
  output logic             trc_clr,
  output logic [NTRAP-1:0] mask,
  output logic [DW-1:0]    dout,
  output logic             hold,
  output logic             step,
  output logic             reg_req,
  output logic             mem_req,
  output logic             io,
  output logic             we,
  output logic [DW-1:0]    addr,
  output logic [DW-1:0]    wdata,
  input  logic             reg_ack,
  input  logic [DW-1:0]    reg_rdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int PADW = DW - REG_W;

  phase_e   phase;
  logic     tgt_reg;
  cmd_cls_t cls;
  logic     accept, acc_ack;
  logic [DW-1:0] acc_rdata;

  dbg_cmd_decode u_dec (.op(cmd_op), .cls(cls));

  assign ready     = en && (phase == PH_IDLE);
  assign dat_ready = en && (phase == PH_DATA);
  assign accept    = cmd_valid && ready;
  assign reg_req   = (phase == PH_ISSUE) && tgt_reg;
  assign mem_req   = (phase == PH_ISSUE) && !tgt_reg;
  assign acc_ack   = tgt_reg ? reg_ack : mem_ack;
  assign acc_rdata = tgt_reg ? reg_rdata : mem_rdata;
  assign trc_clr   = accept && (cmd_op == OP_TRC_OFF || cmd_op == OP_DBG_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; done <= 1'b0; err <= 1'b0; refd <= 1'b0;
      run <= 1'b0; con <= 1'b0; trc_on <= 1'b0; mask <= '0;
      dout <= '0; hold <= 1'b0; step <= 1'b0; tgt_reg <= 1'b0;
      io <= 1'b0; we <= 1'b0; addr <= '0; wdata <= '0;
    end else begin
      step <= 1'b0;
      if (accept) begin
        done <= 1'b0;
        hold <= 1'b0;
        if (!cls.known) begin
          err <= 1'b1; done <= 1'b1;
        end else if (cls.bus && trc_on) begin
          refd <= 1'b1; done <= 1'b1;
        end else if (cls.rd_acc || cls.wr_acc) begin
          addr    <= cls.tgt_reg ? {{PADW{1'b0}}, din[REG_W-1:0]} : din;
          we      <= cls.wr_acc;
          tgt_reg <= cls.tgt_reg;
          io      <= cls.io;
          phase   <= cls.wr_acc ? PH_DATA : PH_ISSUE;
        end else begin
          done <= 1'b1;
          case (cmd_op)
            OP_RUN:     run <= 1'b1;
            OP_HALT:    run <= 1'b0;
            OP_STEP:    step <= !run;
            OP_CON_ON:  con <= 1'b1;
            OP_CON_OFF: con <= 1'b0;
            OP_DBG_RST: begin
              mask <= '0; con <= 1'b0; trc_on <= 1'b0; err <= 1'b0; refd <= 1'b0;
            end
            OP_TRC_ON:  trc_on <= 1'b1;
            OP_TRC_OFF: trc_on <= 1'b0;
            OP_WR_MASK: mask <= din[NTRAP-1:0];
            OP_RD_MASK: begin dout <= DW'(mask); hold <= 1'b1; end
            OP_RD_ID:   begin dout <= PORT_ID; hold <= 1'b1; end
            OP_CLR_FLG: begin err <= 1'b0; refd <= 1'b0; end
            default:    ;
          endcase
        end
      end else if (phase == PH_DATA) begin
        if (dat_valid && dat_ready) begin
          wdata <= din;
          phase <= PH_ISSUE;
        end
      end else if (phase == PH_ISSUE && acc_ack) begin
        if (!we) begin
          dout <= acc_rdata;
          hold <= 1'b1;
        end
        done  <= 1'b1;
        phase <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/dbg_trace_stage.sv
`timescale 1ns/1ps
module dbg_trace_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trc_on,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  output logic          tv,
  output logic [DW-1:0] tdata
);
  assign in_ready = !trc_on || !tv || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv    <= 1'b0;
      tdata <= '0;
    end else if (clr || !trc_on) begin
      tv <= 1'b0;
    end else if (in_valid && in_ready) begin
      tv    <= 1'b1;
      tdata <= in_data;
    end else if (take) begin
      tv <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_cmd_port.sv
`timescale 1ns/1ps
module dbg_cmd_port
  import dbg_cmd_port_pkg::*;
#(
  parameter int DW = 32,
  parameter int REG_W = 5,
  parameter int NTRAP = 16,
  parameter logic [DW-1:0] PORT_ID = 32'h0D1B_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_en,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [DW-1:0]    dbus_in,
  input  logic             dat_valid,
  output logic             dat_ready,
  output logic [SW-1:0]    status,
  output logic [DW-1:0]    dbus_out,
  output logic             dbus_oe,
  output logic             reg_req,
  input  logic             reg_ack,
  input  logic [DW-1:0]    reg_rdata,
  output logic             mem_req,
  output logic             mem_io,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             acc_we,
  output logic [DW-1:0]    acc_addr,
  output logic [DW-1:0]    acc_wdata,
  output logic             cpu_run,
  output logic             cpu_step,
  output logic             console_mode,
  output logic [NTRAP-1:0] trap_mask,
  input  logic             trc_valid,
  input  logic [DW-1:0]    trc_data,
  output logic             trc_ready,
  input  logic             trc_take
);
  logic ready, done, err, refd, trc_on, trc_clr, hold, tv;
  logic [DW-1:0] dout, tdata;

  dbg_cmd_seq #(.DW(DW), .REG_W(REG_W), .NTRAP(NTRAP), .PORT_ID(PORT_ID)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(dbg_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .din(dbus_in), .dat_valid(dat_valid), .ready(ready), .dat_ready(dat_ready),
    .done(done), .err(err), .refd(refd), .run(cpu_run), .con(console_mode),
    .trc_on(trc_on), .trc_clr(trc_clr), .mask(trap_mask), .dout(dout), .hold(hold),
    .step(cpu_step), .reg_req(reg_req), .mem_req(mem_req), .io(mem_io), .we(acc_we),
    .addr(acc_addr), .wdata(acc_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  dbg_trace_stage #(.DW(DW)) u_trc (
    .clk(clk), .rst_n(rst_n), .trc_on(trc_on), .clr(trc_clr), .in_valid(trc_valid),
    .in_data(trc_data), .in_ready(trc_ready), .take(trc_take), .tv(tv), .tdata(tdata)
  );

  always_comb begin
    status              = '0;
    status[ST_READY]    = ready;
    status[ST_DONE]     = done;
    status[ST_TVALID]   = tv;
    status[ST_ERR]      = err;
    status[ST_REFUSED]  = refd;
    status[ST_RUN]      = cpu_run;
    status[ST_CONSOLE]  = console_mode;
    status[ST_TRACING]  = trc_on;
    status[ST_WANTDAT]  = dat_ready;
  end

  assign dbus_out = tv ? tdata : dout;
  assign dbus_oe  = dbg_en && (tv || hold);
endmodule

// File: rtl/dbg_cmd_port_chk.sv
`timescale 1ns/1ps
module dbg_cmd_port_chk #(
  parameter int DW = 32,
  parameter int NTRAP = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_en,
  input logic             cmd_valid,
  input logic [7:0]       cmd_op,
  input logic [13:0]      status,
  input logic [DW-1:0]    dbus_out,
  input logic             dbus_oe,
  input logic             dat_ready,
  input logic             reg_req,
  input logic             reg_ack,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [DW-1:0]    acc_addr,
  input logic             cpu_run,
  input logic             cpu_step,
  input logic             console_mode,
  input logic [NTRAP-1:0] trap_mask,
  input logic             trc_take
);
  logic taken, bus_op;
  assign taken  = cmd_valid && status[0];
  assign bus_op = (cmd_op >= 8'h01 && cmd_op <= 8'h06) || cmd_op == 8'h10 || cmd_op == 8'h11;

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req || mem_req) |-> !status[0]);
  // R1
  done_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && dbg_en) |-> status[0]);
  // R5
  reg_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(acc_addr)));
  // R5
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(acc_addr)));
  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && mem_req));
  // R6
  step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_step |=> !cpu_step);
  // R8
  trace_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !trc_take && !taken) |=> (status[2] && $stable(dbus_out)));
  // R10
  refuse_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && status[7] && bus_op) |=> (status[4] && !reg_req && !mem_req && status[1]));
  // R11
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cmd_op > 8'h12) |=> (status[3] && status[1] && $stable(trap_mask)
      && $stable(cpu_run) && $stable(console_mode) && $stable(status[7])));
  // R14
  parked_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |-> (!status[0] && !dat_ready && !dbus_oe));
endmodule

bind dbg_cmd_port dbg_cmd_port_chk #(.DW(DW), .NTRAP(NTRAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .status(status), .dbus_out(dbus_out), .dbus_oe(dbus_oe), .dat_ready(dat_ready),
  .reg_req(reg_req), .reg_ack(reg_ack), .mem_req(mem_req), .mem_ack(mem_ack),
  .acc_addr(acc_addr), .cpu_run(cpu_run), .cpu_step(cpu_step),
  .console_mode(console_mode), .trap_mask(trap_mask), .trc_take(trc_take)
);

// File: tb/dbg_cmd_port_bench.sv
`timescale 1ns/1ps
module dbg_cmd_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, dbg_en = 1'b1, cmd_valid = 1'b0, dat_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [31:0] dbus_in = '0;
  logic trc_valid = 1'b0, trc_take = 1'b0;
  logic [31:0] trc_data = 32'h7000_0000;
  logic reg_ack, mem_ack;
  logic [31:0] reg_rdata, mem_rdata;
  logic [13:0] status;
  logic [31:0] dbus_out, acc_addr, acc_wdata;
  logic dbus_oe, dat_ready, reg_req, mem_req, mem_io, acc_we;
  logic cpu_run, cpu_step, console_mode, trc_ready;
  logic [15:0] trap_mask;

  int n_chk = 0, n_fail = 0, cyc = 0, wcnt = 0, ack_delay = 0, take_mode = 0;
  bit started = 0, hs_q = 0;

  dbg_cmd_port u_dbg_cmd_port (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .dbus_in(dbus_in), .dat_valid(dat_valid), .dat_ready(dat_ready), .status(status),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe), .reg_req(reg_req), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_io(mem_io), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .cpu_run(cpu_run), .cpu_step(cpu_step), .console_mode(console_mode),
    .trap_mask(trap_mask), .trc_valid(trc_valid), .trc_data(trc_data),
    .trc_ready(trc_ready), .trc_take(trc_take)
  );

  // responders
  function automatic logic [31:0] reg_val(input logic [31:0] a);
    return (a * 32'h0101_0101) ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] mem_val(input logic [31:0] a, input bit isio);
    return a ^ (isio ? 32'h10F0_0000 : 32'h5A5A_5A5A);
  endfunction
  assign reg_ack   = reg_req && (wcnt >= ack_delay);
  assign mem_ack   = mem_req && (wcnt >= ack_delay);
  assign reg_rdata = reg_val(acc_addr);
  assign mem_rdata = mem_val(acc_addr, mem_io);
  always @(posedge clk) wcnt <= ((reg_req || mem_req) && !(reg_ack || mem_ack)) ? wcnt + 1 : 0;

  // trace source and host take pattern
  always @(negedge clk) hs_q = trc_valid && trc_ready;
  always @(posedge clk) begin
    #2;
    if (hs_q) trc_data = trc_data + 32'h0001_0003;
    case (take_mode)
      0: trc_take = 1'b0;
      1: trc_take = 1'b1;
      default: trc_take = ~trc_take;
    endcase
  end

  // behavioural reference model
  int m_ph = 0;
  bit m_done, m_err, m_ref, m_run, m_con, m_trc, m_tv, m_hold, m_step, m_we, m_tgt, m_io;
  logic [31:0] m_tdata, m_dout, m_addr, m_wdata;
  logic [15:0] m_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_err = 0; m_ref = 0; m_run = 0; m_con = 0; m_trc = 0;
      m_tv = 0; m_hold = 0; m_step = 0; m_we = 0; m_tgt = 0; m_io = 0;
      m_tdata = 0; m_dout = 0; m_addr = 0; m_wdata = 0; m_mask = 0;
    end else begin
      bit take_cmd, stop_trc, rdy;
      bit is_bus;
      take_cmd = cmd_valid && dbg_en && m_ph == 0;
      stop_trc = take_cmd && (cmd_op == 8'h0E || cmd_op == 8'h0C);
      rdy = !m_trc || !m_tv || trc_take;
      if (stop_trc || !m_trc) m_tv = 0;
      else if (trc_valid && rdy) begin m_tv = 1; m_tdata = trc_data; end
      else if (trc_take) m_tv = 0;
      m_step = 0;
      is_bus = (cmd_op >= 1 && cmd_op <= 6) || cmd_op == 8'h10 || cmd_op == 8'h11;
      if (take_cmd) begin
        m_done = 0; m_hold = 0;
        if (cmd_op > 8'h12) begin m_err = 1; m_done = 1; end
        else if (is_bus && m_trc) begin m_ref = 1; m_done = 1; end
        else if (cmd_op >= 1 && cmd_op <= 6) begin
          m_tgt = cmd_op <= 2;
          m_io  = cmd_op >= 5;
          m_we  = cmd_op[0] == 1'b0;
          m_addr = m_tgt ? {27'd0, dbus_in[4:0]} : dbus_in;
          m_ph = m_we ? 1 : 2;
        end else begin
          m_done = 1;
          case (cmd_op)
            8'h07: m_run = 1;
            8'h08: m_run = 0;
            8'h09: m_step = !m_run;
            8'h0A: m_con = 1;
            8'h0B: m_con = 0;
            8'h0C: begin m_mask = 0; m_con = 0; m_trc = 0; m_err = 0; m_ref = 0; end
            8'h0D: m_trc = 1;
            8'h0E: m_trc = 0;
            8'h0F: m_mask = dbus_in[15:0];
            8'h10: begin m_dout = {16'd0, m_mask}; m_hold = 1; end
            8'h11: begin m_dout = 32'h0D1B_0001; m_hold = 1; end
            8'h12: begin m_err = 0; m_ref = 0; end
            default: ;
          endcase
        end
      end else if (m_ph == 1) begin
        if (dat_valid && dbg_en) begin m_wdata = dbus_in; m_ph = 2; end
      end else if (m_ph == 2 && (m_tgt ? reg_ack : mem_ack)) begin
        if (!m_we) begin m_dout = m_tgt ? reg_val(m_addr) : mem_val(m_addr, m_io); m_hold = 1; end
        m_done = 1; m_ph = 0;
      end
    end
    started = 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R1", "ready", status[0], dbg_en && m_ph == 0);
    chk("R1", "done", status[1], m_done);
    chk("R1", "zero bits", status[13:9], 0);
    chk("R8", "trace valid", status[2], m_tv);
    chk("R11", "error flag", status[3], m_err);
    chk("R10", "refused flag", status[4], m_ref);
    chk("R6", "running", status[5], m_run);
    chk("R6", "cpu_run pin", cpu_run, m_run);
    chk("R6", "cpu_step", cpu_step, m_step);
    chk("R7", "console bit", status[6], m_con);
    chk("R7", "console pin", console_mode, m_con);
    chk("R8", "tracing bit", status[7], m_trc);
    chk("R4", "awaiting data bit", status[8], dbg_en && m_ph == 1);
    chk("R4", "dat_ready", dat_ready, dbg_en && m_ph == 1);
    chk("R9", "trc_ready", trc_ready, !m_trc || !m_tv || trc_take);
    chk("R4", "dbus_oe", dbus_oe, dbg_en && (m_tv || m_hold));
    if (m_tv) chk("R8", "trace word", dbus_out, m_tdata);
    else if (m_hold) chk("R4", "read value", dbus_out, m_dout);
    chk("R2", "reg_req", reg_req, m_ph == 2 && m_tgt);
    chk("R3", "mem_req", mem_req, m_ph == 2 && !m_tgt);
    if (m_ph == 2) begin
      chk("R5", "acc_addr", acc_addr, m_addr);
      chk("R4", "acc_we", acc_we, m_we);
      if (m_we) chk("R4", "acc_wdata", acc_wdata, m_wdata);
      if (!m_tgt) chk("R3", "mem_io", mem_io, m_io);
    end
    chk("R13", "trap_mask", trap_mask, m_mask);
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=%0d expected=<150000 cycles", cyc);
      report();
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic send(input logic [7:0] op, input logic [31:0] d);
    while (!status[0]) tick(1);
    cmd_valid = 1; cmd_op = op; dbus_in = d;
    tick(1);
    cmd_valid = 0;
  endtask
  task automatic give(input logic [31:0] d);
    while (!dat_ready) tick(1);
    dat_valid = 1; dbus_in = d;
    tick(1);
    dat_valid = 0;
  endtask
  task automatic finish_cmd();
    while (!status[1]) tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset status", {18'd0, status}, 32'h1);
    tick(1);
    // R6 run/step
    send(8'h07, 0); chk("R6", "run set", cpu_run, 1);
    send(8'h09, 0); @(negedge clk); chk("R6", "no step while running", cpu_step, 0); tick(1);
    send(8'h08, 0);
    send(8'h09, 0); @(negedge clk); chk("R6", "step pulse", cpu_step, 1); tick(2);
    // R7 console / R12 no-op
    send(8'h0A, 0); send(8'h00, 0); chk("R7", "console on", console_mode, 1);
    send(8'h0B, 0); chk("R7", "console off", console_mode, 0);
    // R2 register write, delayed data, busy host command
    ack_delay = 2;
    send(8'h02, 32'hFFFF_FFF7);
    cmd_valid = 1; cmd_op = 8'h07; tick(3);
    chk("R1", "busy not taken", cpu_run, 0);
    cmd_valid = 0;
    give(32'hDEAD_BEEF); finish_cmd();
    ack_delay = 0;
    send(8'h01, 32'h0000_0105); finish_cmd(); @(negedge clk);
    chk("R2", "reg read value", dbus_out, reg_val(32'h5));
    tick(1);
    // R3 memory and I/O
    ack_delay = 3;
    send(8'h04, 32'h8000_1000); tick(4); give(32'h1234_5678); finish_cmd();
    send(8'h03, 32'h8000_2004); finish_cmd(); @(negedge clk);
    chk("R3", "mem read value", dbus_out, mem_val(32'h8000_2004, 0));
    tick(1); ack_delay = 1;
    send(8'h05, 32'h0000_0040); finish_cmd(); @(negedge clk);
    chk("R3", "io read value", dbus_out, mem_val(32'h40, 1));
    tick(1);
    send(8'h06, 32'h0000_0044); give(32'hCAFE_0001); finish_cmd();
    // R13 mask and identity
    send(8'h0F, 32'hFFFF_A5C3); chk("R13", "mask load", trap_mask, 16'hA5C3);
    send(8'h10, 0); @(negedge clk); chk("R13", "mask readback", dbus_out, 32'h0000_A5C3); tick(1);
    send(8'h11, 0); @(negedge clk); chk("R13", "identity", dbus_out, 32'h0D1B_0001); tick(1);
    // R11 unknown opcodes
    send(8'h13, 32'h0000_FFFF); send(8'hFF, 0); @(negedge clk);
    chk("R11", "error set", status[3], 1); chk("R11", "mask kept", trap_mask, 16'hA5C3);
    tick(1);
    send(8'h12, 0); chk("R12", "flags cleared", status[4:3], 0);
    // R9 trace off discards
    trc_valid = 1; tick(5); chk("R9", "no word while off", status[2], 0);
    // R8 trace stream with back-pressure patterns
    send(8'h0D, 0); take_mode = 0; tick(6);
    chk("R8", "word held", status[2], 1);
    take_mode = 2; tick(20); take_mode = 1; tick(10);
    // R10 refusals
    send(8'h01, 32'h3); @(negedge clk); chk("R10", "refused", status[4], 1); chk("R10", "no req", reg_req, 0);
    tick(1);
    send(8'h04, 32'h10); send(8'h10, 0);
    chk("R10", "no data phase", dat_ready, 0);
    send(8'h0E, 0); tick(3); chk("R9", "stop drops word", status[2], 0);
    // R12 debug reset
    send(8'h0D, 0); send(8'h0A, 0); send(8'h07, 0); send(8'h13, 0); tick(3);
    send(8'h0C, 0); @(negedge clk);
    chk("R12", "mask clear", trap_mask, 0); chk("R12", "console clear", console_mode, 0);
    chk("R12", "trace clear", status[7], 0); chk("R12", "flags clear", status[4:3], 0);
    chk("R12", "run kept", cpu_run, 1);
    tick(1); trc_valid = 0; take_mode = 0;
    // R14 parked port
    send(8'h08, 0);
    dbg_en = 0; cmd_valid = 1; cmd_op = 8'h07; tick(4);
    chk("R14", "not ready", status[0], 0); chk("R14", "not taken", cpu_run, 0);
    dbg_en = 1; tick(1); cmd_valid = 0;
    chk("R14", "taken after enable", cpu_run, 1);
    tick(4);
    report();
  end
endmodule